// File: doc/BRIEF.md
# Two-Line Character Display Message Sequencer

This block drives a command/data stream into a character-display driver so that a complete two-row message is written. Each word it offers is 10 bits wide. It first sends a cursor-position command for the start of row 1, then the row 1 characters, then a cursor-position command for the start of row 2, then the row 2 characters. After that it stops and raises a completion flag.

The downstream driver raises `out_ready` only when it is idle. Each word is offered with `out_valid` and stays in place until a cycle in which both `out_valid` and `out_ready` are high. After each such handshake the sequencer drops `out_valid` for at least one cycle before it offers the next word.

The text of both rows is held in constant parameters. A `restart` pulse given after completion writes the whole message again.

Top module: `lcd_msg_seq`

## Requirements
- R1: Every word has the layout bit 9 = register-select, bit 8 = read/write, bits 7:0 = byte. Bit 8 is always 0. Cursor-position commands carry bit 9 = 0, and character words carry bit 9 = 1 (for example 'H' is 10'h248).
- R2: The first word offered after reset, and after each honoured restart, is 10'h080. This is the command that places the cursor at row 1, column 0.
- R3: Words 1 to 16 are the 16 row-1 characters in column order. Each is encoded as {2'b10, ascii}.
- R4: Word 17 is 10'h0C0. This is the command that places the cursor at address 0x40, the start of row 2.
- R5: Words 18 to 33 are the 16 row-2 characters in column order. Each is encoded as {2'b10, ascii}. No word of the 34-word sequence is skipped or repeated.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high in the next cycle and `out_word` does not change.
- R7: In the cycle after a handshake, `out_valid` is low.
- R8: Once the 34th word has been accepted, `done` is high and `out_valid` is low. Both hold until a restart is honoured.
- R9: A `restart` pulse while `done` is high clears `done` and begins the sequence again at R2.
- R10: A `restart` pulse while the message is still being sent has no effect. The remaining words follow unchanged, and the message completes normally.
- R11: While the synchronous active-high `rst` is high, `out_valid` and `done` are cleared in the next cycle, and the word index returns to the row-1 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Single-cycle request to write the message again once it is complete |
| out_ready | input | 1 | Downstream driver is idle and will take the word |
| out_valid | output | 1 | A word is being offered |
| out_word | output | 10 | {register-select, read/write, byte} |
| done | output | 1 | The whole message has been accepted |

## Verification
The assertions assume that `out_ready` is a level that the driver may raise at any time. They assume nothing about when it returns, and they need `restart` only as a pulse. The bench keeps `out_ready` low for a swept number of cycles, from 0 to 6, before each word. It raises `out_ready` for exactly one cycle, so that every word is accepted exactly once. It pulses `restart` both mid-message and after completion, and it checks each accepted word against its own copy of the expected 34-word order.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
   localparam int WORD_W = 10;
   typedef logic [WORD_W-1:0] lcd_word_t;
   typedef enum logic [1:0] {
      ST_GAP   = 2'd0,
      ST_OFFER = 2'd1,
      ST_DONE  = 2'd2
   } seq_state_t;
   function automatic lcd_word_t pos_cmd(input logic [6:0] addr);
      return {2'b00, 1'b1, addr};
   endfunction
   function automatic lcd_word_t char_word(input logic [7:0] ch);
      return {2'b10, ch};
   endfunction
endpackage

// File: rtl/lcdseq_text.sv
module lcdseq_text #(
   parameter int COLS = 16,
   parameter int IW = 6,
   parameter logic [8*COLS-1:0] TEXT = {COLS{8'h20}}
) (
   input  logic [IW-1:0] col,
   output logic [7:0]    ch
);
   always_comb begin
      ch = 8'h20;
      for (int i = 0; i < COLS; i++)
         if (col == IW'(i)) ch = TEXT[8*(COLS-1-i) +: 8];
   end
endmodule

// File: rtl/lcdseq_encode.sv
module lcdseq_encode
   import lcdseq_pkg::*;
#(
   parameter int COLS = 16,
   parameter int IW = 6,
   parameter logic [6:0] ROW1_ADDR = 7'h00,
   parameter logic [6:0] ROW2_ADDR = 7'h40,
   parameter logic [8*COLS-1:0] ROW1_TEXT = {COLS{8'h20}},
   parameter logic [8*COLS-1:0] ROW2_TEXT = {COLS{8'h20}}
) (
   input  logic [IW-1:0] idx,
   output lcd_word_t     word
);
   localparam logic [IW-1:0] ROW2_CMD_IDX = IW'(COLS + 1);
   logic [IW-1:0] col1, col2;
   logic [7:0]    ch1, ch2;

   assign col1 = idx - IW'(1);
   assign col2 = idx - IW'(COLS + 2);

   lcdseq_text #(.COLS(COLS), .IW(IW), .TEXT(ROW1_TEXT)) u_row1 (.col(col1), .ch(ch1));
   lcdseq_text #(.COLS(COLS), .IW(IW), .TEXT(ROW2_TEXT)) u_row2 (.col(col2), .ch(ch2));

   always_comb begin
      if (idx == '0)                 word = pos_cmd(ROW1_ADDR);
      else if (idx < ROW2_CMD_IDX)   word = char_word(ch1);
      else if (idx == ROW2_CMD_IDX)  word = pos_cmd(ROW2_ADDR);
      else                           word = char_word(ch2);
   end
endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
   import lcdseq_pkg::*;
#(
   parameter int TOTAL = 34,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  logic          ready,
   output logic [IW-1:0] idx,
   output logic          valid,
   output logic          done
);
   localparam logic [IW-1:0] LAST = IW'(TOTAL - 1);
   seq_state_t state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_GAP;
         idx   <= '0;
      end else begin
         case (state)
            ST_GAP:   state <= ST_OFFER;
            ST_OFFER: if (ready) begin
               if (idx == LAST) state <= ST_DONE;
               else begin
                  idx   <= idx + IW'(1);
                  state <= ST_GAP;
               end
            end
            ST_DONE:  if (restart) begin
               idx   <= '0;
               state <= ST_GAP;
            end
            default:  state <= ST_GAP;
         endcase
      end
   end

   assign valid = (state == ST_OFFER);
   assign done  = (state == ST_DONE);
endmodule

// File: rtl/lcd_msg_seq.sv
module lcd_msg_seq
   import lcdseq_pkg::*;
#(
   parameter int COLS = 16,
   parameter logic [6:0] ROW1_ADDR = 7'h00,
   parameter logic [6:0] ROW2_ADDR = 7'h40,
   parameter logic [8*COLS-1:0] ROW1_TEXT = "  Hello World   ",
   parameter logic [8*COLS-1:0] ROW2_TEXT = "   Second Row   ",
   parameter bit RESTART_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       restart,
   input  logic       out_ready,
   output logic       out_valid,
   output logic [9:0] out_word,
   output logic       done
);
   localparam int TOTAL = 2*COLS + 2;
   localparam int IW = $clog2(TOTAL + 1);

   if (COLS < 1 || COLS > 40) begin : g_bad_cols
      $error("lcd_msg_seq: COLS must be 1..40");
   end
   if (ROW1_ADDR == ROW2_ADDR) begin : g_bad_addr
      $error("lcd_msg_seq: row start addresses must differ");
   end

   logic          restart_q;
   logic [IW-1:0] idx;

   if (RESTART_EN) begin : g_restart
      assign restart_q = restart;
   end else begin : g_no_restart
      logic unused_restart;
      assign unused_restart = restart;
      assign restart_q = 1'b0;
   end

   lcdseq_ctrl #(.TOTAL(TOTAL), .IW(IW)) u_ctrl (
      .clk(clk), .rst(rst), .restart(restart_q), .ready(out_ready),
      .idx(idx), .valid(out_valid), .done(done)
   );

   lcdseq_encode #(
      .COLS(COLS), .IW(IW), .ROW1_ADDR(ROW1_ADDR), .ROW2_ADDR(ROW2_ADDR),
      .ROW1_TEXT(ROW1_TEXT), .ROW2_TEXT(ROW2_TEXT)
   ) u_enc (
      .idx(idx), .word(out_word)
   );
endmodule

// File: rtl/lcd_msg_seq_chk.sv
module lcd_msg_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       restart,
   input logic       out_ready,
   input logic       out_valid,
   input logic [9:0] out_word,
   input logic       done
);
   AST_RW_CLEAR: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !out_word[8]); // R1
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_word)); // R6
   AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready |=> !out_valid); // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      done |-> !out_valid); // R8
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      done && !restart |=> done); // R8
   AST_RESTART_LEAVES: assert property (@(posedge clk) disable iff (rst)
      done && restart |=> !done && !out_valid); // R9
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !out_valid && !done); // R11
endmodule

bind lcd_msg_seq lcd_msg_seq_chk u_chk (
   .clk(clk), .rst(rst), .restart(restart), .out_ready(out_ready),
   .out_valid(out_valid), .out_word(out_word), .done(done)
);

// File: tb/lcd_msg_seq_tb.sv
module lcd_msg_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [127:0] TXT1 = "  Hello World   ";
   localparam logic [127:0] TXT2 = "   Second Row   ";

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       restart = 1'b0;
   logic       out_ready = 1'b0;
   logic       out_valid;
   logic [9:0] out_word;
   logic       done;
   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_msg_seq u_dut (
      .clk(clk), .rst(rst), .restart(restart), .out_ready(out_ready),
      .out_valid(out_valid), .out_word(out_word), .done(done)
   );

   function automatic logic [9:0] exp_word(input int k);
      if (k == 0)       return 10'h080;
      else if (k <= 16) return {2'b10, TXT1[8*(16-k) +: 8]};
      else if (k == 17) return 10'h0C0;
      else              return {2'b10, TXT2[8*(33-k) +: 8]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag_for(input int k);
      if (k == 0) return "R2";
      else if (k <= 16) return "R3";
      else if (k == 17) return "R4";
      else return "R5";
   endfunction

   // Send one full message; delay sets cycles ready stays low; pulse_at puts a restart mid-message (R10)
   task automatic run_message(input int max_delay, input int pulse_at);
      for (int k = 0; k < 34; k++) begin
         int w = 0;
         while (!out_valid && w < 8) begin @(negedge clk); w++; end
         check(out_valid, "R7", {31'b0, out_valid}, 32'h1);
         check(out_word == exp_word(k), tag_for(k), {22'b0, out_word}, {22'b0, exp_word(k)});
         check(out_word[8] == 1'b0, "R1", {31'b0, out_word[8]}, 32'h0);
         for (int d = 0; d < (k % (max_delay + 1)); d++) begin
            if (k == pulse_at && d == 0) restart = 1'b1;
            @(negedge clk);
            restart = 1'b0;
            check(out_valid && out_word == exp_word(k), "R6", {22'b0, out_word}, {22'b0, exp_word(k)});
         end
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
         check(!out_valid, "R7", {31'b0, out_valid}, 32'h0);
      end
      check(done && !out_valid, "R8", {30'b0, done, out_valid}, 32'h2);
      repeat (3) @(negedge clk);
      check(done && !out_valid, "R8", {30'b0, done, out_valid}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid && !done, "R11", {30'b0, out_valid, done}, 32'h0);
      rst = 1'b0;
      run_message(0, -1);
      for (int md = 1; md <= 6; md++) begin
         restart = 1'b1;
         @(negedge clk);
         restart = 1'b0;
         check(!done, "R9", {31'b0, done}, 32'h0);
         run_message(md, (md == 3) ? 5 : ((md == 5) ? 20 : -1));
      end
      // reset mid-message returns to the row-1 command
      restart = 1'b1; @(negedge clk); restart = 1'b0;
      repeat (2) @(negedge clk);
      out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b1; @(negedge clk);
      check(!out_valid && !done, "R11", {30'b0, out_valid, done}, 32'h0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid && out_word == 10'h080, "R11", {22'b0, out_word}, 32'h080);
      finished = 1;
   end

   initial begin
      int cyc = 0;
      while (!finished && cyc < 50000) begin @(negedge clk); cyc++; end
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule